// File: doc/BRIEF.md
# Resynchronizable Serial Control Port

This block is a serial configuration port. A host clocks instruction and data bits into it on a serial clock while chip select is low. Through this port the host can write and read a small file of byte-wide registers. Every transfer opens with one instruction byte. Bit 7 of that byte selects read (1) or write (0), and bits 6:0 give the starting register address. Data bytes then follow, one per register, and the address advances by one after each byte. The register contents appear in parallel on `regs_o`. The 32-bit tuning word is also brought out on its own port.

The serial pins are sampled by the block's own clock `clk`, and a rising edge of the serial clock is detected inside the block. If the host and the port lose framing, raising and then lowering the resync input puts the port back at the start of an instruction byte. The registers keep their contents through this. Register 0 selects the bit order: bit 6 set means least significant bit first. Register 0 bit 7 set makes the data pin input-only, and read data then leaves on a separate output.

The protocol state machine has five states. IDLE: chip select high. INSTR: collecting the instruction byte. WDATA: collecting write bytes. RDATA: shifting out read bytes. RESYNC: resync held high. The transitions are:
- IDLE→INSTR when chip select falls.
- INSTR→WDATA or INSTR→RDATA on the eighth edge, chosen by bit 7.
- Any state→RESYNC while resync is high.
- RESYNC→INSTR on release with chip select low, or RESYNC→IDLE on release with chip select high.
- Any non-resync state→IDLE when chip select rises.

Top module: `scp_ctrl_port`

## Requirements
- R1: After reset every register reads 0, and `sdio_oe`, `sdio_out` and `sdo` are low.
- R2: The first eight serial clock rising edges after chip select falls form the instruction byte. Bit 7 = 1 means read and 0 means write. Bits 6:0 are the address.
- R3: During a write, a data byte is committed to the current address on its eighth rising edge. Each later byte goes to the next higher address.
- R4: During a read, the first data bit of the addressed register is valid before the first data-phase rising edge. Each following bit is valid after the next rising edge. Successive bytes come from successive addresses.
- R5: Register 0 bit 6 = 1 makes both instruction and data bits travel least significant bit first. 0 means most significant bit first.
- R6: Register 0 bit 7 = 0 raises `sdio_oe` during the read data phase, drives read bits on `sdio_out`, and holds `sdo` low. When the bit is 1, `sdio_oe` stays low and read bits appear on `sdo`.
- R7: Register 1 bit 5 always reads 0, whatever is written to it.
- R8: `ftw_o` is the 32-bit tuning word held in registers 2 to 5, with register 2 as the least significant byte.
- R9: While resync is high, the port drives nothing. After resync is released, the next eight rising edges are an instruction byte, and any partial byte is discarded.
- R10: A resync pulse leaves every register value unchanged.
- R11: Raising chip select ends the transfer, drops `sdio_oe` and discards a partial byte. The next transfer starts with an instruction byte.
- R12: A write to an address at or above the register count is ignored, and a read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all serial inputs are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| sync | input | 1 | Protocol resync, active high |
| sdio_in | input | 1 | Serial data from host |
| sdio_out | output | 1 | Read data toward the bidirectional pin |
| sdio_oe | output | 1 | Drive enable for the bidirectional pin |
| sdo | output | 1 | Read data when the data pin is input-only |
| regs_o | output | NREG*8 | All registers, register n at bits 8n+7:8n |
| ftw_o | output | 32 | Tuning word from registers 2..5 |

## Verification
A bit counter that slips by one position shows up at once: every later byte of the transfer lands in the wrong register with rotated contents. The register image on `regs_o` exposes this on the cycle the byte commits. A state machine that misreads the read/write flag either corrupts a register on a read or leaves `sdio_oe` low for the whole data phase, and both are visible within the first data byte. A resync or chip-select recovery that does not reset the counter leaves the next instruction misframed, so the very next write lands at a wrong address. Each sweep ends by comparing the whole register image with an arithmetic model.

// File: rtl/scp_pkg.sv
package scp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INSTR,
        ST_WDATA,
        ST_RDATA,
        ST_RESYNC
    } scp_state_e;

    localparam int BYTE_W         = 8;
    localparam int ADDR_W         = 7;
    localparam int CNT_W          = $clog2(BYTE_W);
    localparam int CFG_ADDR       = 0;
    localparam int CFG_LSB_BIT    = 6;
    localparam int CFG_INONLY_BIT = 7;
    localparam int RSV_ADDR       = 1;
    localparam int RSV_BIT        = 5;
    localparam int FTW_BASE       = 2;
    localparam int FTW_BYTES      = 4;
endpackage

// File: rtl/scp_sampler.sv
module scp_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sync,
    input  logic sdio_in,
    output logic sclk_rise,
    output logic cs_act,
    output logic sync_s,
    output logic sdi_s
);
    logic sclk_q1, sclk_q2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q1 <= 1'b0;
            sclk_q2 <= 1'b0;
            cs_act  <= 1'b0;
            sync_s  <= 1'b0;
            sdi_s   <= 1'b0;
        end else begin
            sclk_q1 <= sclk;
            sclk_q2 <= sclk_q1;
            cs_act  <= ~cs_n;
            sync_s  <= sync;
            sdi_s   <= sdio_in;
        end
    end

    assign sclk_rise = sclk_q1 & ~sclk_q2;
endmodule

// File: rtl/scp_fsm.sv
module scp_fsm
    import scp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_rise,
    input  logic cs_act,
    input  logic sync_s,
    input  logic instr_rd,
    output logic shift_en,
    output logic instr_done,
    output logic wdata_done,
    output logic rdata_done,
    output logic rd_phase
);
    scp_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              active;
    logic              byte_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (sync_s || !cs_act)
                cnt_q <= '0;
            else if (shift_en)
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (sync_s) begin
            state_d = ST_RESYNC;
        end else if (!cs_act) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_INSTR;
                ST_RESYNC: state_d = ST_INSTR;
                ST_INSTR:  if (instr_done) state_d = instr_rd ? ST_RDATA : ST_WDATA;
                ST_WDATA:  state_d = ST_WDATA;
                ST_RDATA:  state_d = ST_RDATA;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        active     = (state_q == ST_INSTR) || (state_q == ST_WDATA) || (state_q == ST_RDATA);
        shift_en   = sclk_rise && cs_act && !sync_s && active;
        byte_done  = shift_en && (cnt_q == CNT_W'(BYTE_W - 1));
        instr_done = byte_done && (state_q == ST_INSTR);
        wdata_done = byte_done && (state_q == ST_WDATA);
        rdata_done = byte_done && (state_q == ST_RDATA);
        rd_phase   = (state_q == ST_RDATA) && cs_act && !sync_s;
    end
endmodule

// File: rtl/scp_shift.sv
module scp_shift
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              instr_done,
    input  logic              wdata_done,
    input  logic              rdata_done,
    input  logic              rd_phase,
    input  logic              sdi,
    input  logic              lsb_first,
    input  logic              in_only,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] byte_next,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic              sdo
);
    logic [BYTE_W-1:0] in_sr, out_sr;
    logic [ADDR_W-1:0] addr_q;
    logic              cur_bit;

    always_comb begin
        if (lsb_first) byte_next = {sdi, in_sr[BYTE_W-1:1]};
        else           byte_next = {in_sr[BYTE_W-2:0], sdi};
        rd_addr = instr_done ? byte_next[ADDR_W-1:0] : addr_q + ADDR_W'(1);
        wr_en   = wdata_done;
        wr_addr = addr_q;
        wr_data = byte_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_sr  <= '0;
            out_sr <= '0;
            addr_q <= '0;
        end else begin
            if (shift_en)
                in_sr <= byte_next;
            if (instr_done)
                addr_q <= byte_next[ADDR_W-1:0];
            else if (wdata_done || rdata_done)
                addr_q <= addr_q + ADDR_W'(1);
            if (instr_done || rdata_done)
                out_sr <= rd_data;
            else if (shift_en && rd_phase)
                out_sr <= lsb_first ? {1'b0, out_sr[BYTE_W-1:1]}
                                    : {out_sr[BYTE_W-2:0], 1'b0};
        end
    end

    always_comb begin
        cur_bit  = lsb_first ? out_sr[0] : out_sr[BYTE_W-1];
        sdio_oe  = rd_phase && !in_only;
        sdio_out = sdio_oe && cur_bit;
        sdo      = rd_phase && in_only && cur_bit;
    end
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
    import scp_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [BYTE_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [BYTE_W-1:0]      rd_data,
    output logic [NREG*BYTE_W-1:0] regs_o
);
    logic [BYTE_W-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [BYTE_W-1:0] WMASK =
            (g == RSV_ADDR) ? ~(BYTE_W'(1) << RSV_BIT) : '1;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(g)))
                regs_q[g] <= wr_data & WMASK;
        end
        assign regs_o[g*BYTE_W +: BYTE_W] = regs_q[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = regs_q[i];
    end
endmodule

// File: rtl/scp_ctrl_port.sv
module scp_ctrl_port
    import scp_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk,
    input  logic                   cs_n,
    input  logic                   sync,
    input  logic                   sdio_in,
    output logic                   sdio_out,
    output logic                   sdio_oe,
    output logic                   sdo,
    output logic [NREG*BYTE_W-1:0] regs_o,
    output logic [31:0]            ftw_o
);
    logic sclk_rise, cs_act, sync_s, sdi_s;
    logic shift_en, instr_done, wdata_done, rdata_done, rd_phase;
    logic [BYTE_W-1:0] byte_next, wr_data, rd_data;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic wr_en;

    scp_sampler smp_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sync(sync),
        .sdio_in(sdio_in), .sclk_rise(sclk_rise), .cs_act(cs_act),
        .sync_s(sync_s), .sdi_s(sdi_s)
    );

    scp_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .cs_act(cs_act),
        .sync_s(sync_s), .instr_rd(byte_next[BYTE_W-1]), .shift_en(shift_en),
        .instr_done(instr_done), .wdata_done(wdata_done),
        .rdata_done(rdata_done), .rd_phase(rd_phase)
    );

    scp_shift shf_i (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .instr_done(instr_done),
        .wdata_done(wdata_done), .rdata_done(rdata_done), .rd_phase(rd_phase),
        .sdi(sdi_s),
        .lsb_first(regs_o[CFG_ADDR*BYTE_W + CFG_LSB_BIT]),
        .in_only(regs_o[CFG_ADDR*BYTE_W + CFG_INONLY_BIT]),
        .rd_data(rd_data), .byte_next(byte_next), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo)
    );

    scp_regfile #(.NREG(NREG)) rf_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .regs_o(regs_o)
    );

    assign ftw_o = regs_o[FTW_BASE*BYTE_W +: FTW_BYTES*BYTE_W];
endmodule

// File: rtl/scp_ctrl_port_chk.sv
module scp_ctrl_port_chk
    import scp_pkg::*;
#(
    parameter int NREG = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cs_n,
    input logic                   sync,
    input logic                   sdio_out,
    input logic                   sdio_oe,
    input logic                   sdo,
    input logic [NREG*BYTE_W-1:0] regs_o
);
    assert_inonly_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        regs_o[CFG_ADDR*BYTE_W + CFG_INONLY_BIT] |-> !sdio_oe);

    assert_pins_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> !sdo);

    assert_no_out_without_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sdio_oe |-> !sdio_out);

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        regs_o[RSV_ADDR*BYTE_W + RSV_BIT] == 1'b0);

    assert_resync_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (!sdio_oe && !sdo));

    assert_resync_keeps_regs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && $past(sync)) |=> $stable(regs_o));

    assert_deselect_drops_oe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdio_oe);
endmodule

bind scp_ctrl_port scp_ctrl_port_chk #(.NREG(NREG)) chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sync(sync), .sdio_out(sdio_out),
    .sdio_oe(sdio_oe), .sdo(sdo), .regs_o(regs_o)
);

// File: tb/scp_ctrl_port_tb.sv
module scp_ctrl_port_tb_top;
    localparam int NREG = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, sync = 1'b0, sdio_in = 1'b0;
    logic sdio_out, sdio_oe, sdo;
    logic [NREG*8-1:0] regs_o;
    logic [31:0] ftw_o;

    int checks = 0;
    int errs = 0;
    bit done = 0;
    bit lsb = 0;
    bit oe_all, oe_any, sdo_any;
    logic [7:0] model [NREG];

    always #2 clk = ~clk;

    scp_ctrl_port #(.NREG(NREG)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sync(sync),
        .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo),
        .regs_o(regs_o), .ftw_o(ftw_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < NREG; i++) chk(req, regs_o[i*8 +: 8], model[i]);
    endtask

    task automatic model_wr(input logic [6:0] a, input logic [7:0] d);
        if (a < NREG) model[a] = (a == 1) ? (d & 8'hDF) : d;
    endtask

    task automatic send_bit(input logic b, output logic r);
        sclk = 1'b0; sdio_in = b;
        tick(4);
        r = sdio_out | sdo;
        if (!sdio_oe) oe_all = 0;
        if (sdio_oe) oe_any = 1;
        if (sdo) sdo_any = 1;
        sclk = 1'b1;
        tick(4);
    endtask

    task automatic send_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        logic r;
        rx = '0;
        for (int i = 0; i < n; i++) begin
            send_bit(lsb ? tx[i] : tx[7-i], r);
            if (lsb) rx[i] = r; else rx[7-i] = r;
        end
    endtask

    task automatic cs_on;  cs_n = 1'b0; tick(3); endtask
    task automatic cs_off; sclk = 1'b0; tick(2); cs_n = 1'b1; tick(3); endtask

    task automatic pulse_sync;
        sync = 1'b1; tick(4); sync = 1'b0; tick(3);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] rx;
        cs_on;
        send_bits({1'b0, a}, 8, rx);
        send_bits(d, 8, rx);
        cs_off;
        model_wr(a, d);
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] v);
        logic [7:0] rx;
        cs_on;
        send_bits({1'b1, a}, 8, rx);
        oe_all = 1; oe_any = 0; sdo_any = 0;
        send_bits(8'h00, 8, v);
        cs_off;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v, rx;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1 reset state
        chk("R1 regs", regs_o[31:0], 32'h0);
        chk("R1 regs hi", regs_o[63:32], 32'h0);
        chk("R1 pins", {29'h0, sdio_oe, sdio_out, sdo}, 32'h0);

        // R2 R3 R4 R6 R7: sweep MSB-first, bidirectional
        for (int a = 1; a < NREG; a++) begin
            for (int k = 0; k < 3; k++) begin
                logic [7:0] d;
                d = 8'((a * 29 + k * 83 + 7) ^ (k * 16'h5A));
                wr(7'(a), d);
                chk("R3 write sweep", regs_o[a*8 +: 8], model[a]);
                rd(7'(a), v);
                chk("R4 read sweep", v, model[a]);
                chk("R6 oe bidir", {30'h0, oe_all, sdo_any}, 32'h2);
                if (a == 1) chk("R7 reserved", v[5], 1'b0);
            end
        end
        chk_regs("R2 image");

        // R3 R8 burst write of tuning word, R4 burst read
        cs_on;
        send_bits(8'h02, 8, rx);
        send_bits(8'h44, 8, rx); send_bits(8'h33, 8, rx);
        send_bits(8'h22, 8, rx); send_bits(8'h11, 8, rx);
        cs_off;
        model[2] = 8'h44; model[3] = 8'h33; model[4] = 8'h22; model[5] = 8'h11;
        chk("R8 tuning word", ftw_o, 32'h11223344);
        cs_on;
        send_bits(8'h82, 8, rx);
        for (int b = 0; b < 4; b++) begin
            send_bits(8'h00, 8, rx);
            chk("R4 burst read", rx, model[2+b]);
        end
        cs_off;

        // R12 out-of-range
        wr(7'h25, 8'hAB);
        chk_regs("R12 write ignored");
        rd(7'h25, v);
        chk("R12 read zero", v, 8'h00);
        cs_on;
        send_bits(8'h07, 8, rx);
        send_bits(8'h6E, 8, rx); send_bits(8'h99, 8, rx);
        cs_off;
        model[7] = 8'h6E;
        chk_regs("R12 wrap past end");

        // R5 LSB-first
        wr(7'h00, 8'h40);
        lsb = 1;
        for (int a = 1; a < NREG; a++) begin
            logic [7:0] d;
            d = 8'(a * 53 + 17);
            wr(7'(a), d);
            chk("R5 lsb write", regs_o[a*8 +: 8], model[a]);
            rd(7'(a), v);
            chk("R5 lsb read", v, model[a]);
        end

        // R6 input-only
        wr(7'h00, 8'hC0);
        for (int a = 0; a < NREG; a++) begin
            rd(7'(a), v);
            chk("R6 sdo read", v, model[a]);
            chk("R6 no oe", {31'h0, oe_any}, 32'h0);
        end
        wr(7'h00, 8'h00);
        lsb = 0;
        chk("R5 back to msb", regs_o[7:0], 8'h00);

        // R9 R10 resync mid-instruction
        cs_on;
        send_bits(8'hFF, 3, rx);
        pulse_sync;
        send_bits(8'h03, 8, rx);
        send_bits(8'h5C, 8, rx);
        cs_off;
        model[3] = 8'h5C;
        chk_regs("R9 resync instr");

        // R9 R10 resync mid-data
        cs_on;
        send_bits(8'h04, 8, rx);
        send_bits(8'hF0, 5, rx);
        pulse_sync;
        chk_regs("R10 partial kept out");
        send_bits(8'h05, 8, rx);
        send_bits(8'h3A, 8, rx);
        cs_off;
        model[5] = 8'h3A;
        chk_regs("R10 resync data");

        // R9 resync during read drops drive
        cs_on;
        send_bits(8'h83, 8, rx);
        send_bits(8'h00, 3, rx);
        sync = 1'b1; tick(3);
        chk("R9 oe low in resync", {31'h0, sdio_oe}, 32'h0);
        sync = 1'b0; tick(3);
        cs_off;

        // R11 chip select abort
        cs_on;
        send_bits(8'h06, 8, rx);
        send_bits(8'hA5, 4, rx);
        cs_off;
        chk_regs("R11 abort discards");
        cs_on;
        send_bits(8'h86, 8, rx);
        send_bits(8'h00, 4, rx);
        cs_n = 1'b1; tick(3);
        chk("R11 oe drops", {31'h0, sdio_oe}, 32'h0);
        sclk = 1'b0; tick(3);
        wr(7'h06, 8'h77);
        chk("R11 fresh transfer", regs_o[6*8 +: 8], 8'h77);
        chk_regs("R11 image");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule